// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a parameterizable set of interrupt request lines and keeps, for every line, an enable bit, a pending bit, an active bit and a programmable urgency level. Every cycle it selects the most urgent line that is both pending and enabled. It offers that line's number to the processor only when the line is strictly more urgent than the handler that is running at that moment. That condition is what allows handlers to nest.

The processor takes an offered request with a one-cycle `ack` strobe, which moves the line from pending to active. It leaves the handler with a `done` strobe that carries the line number. A line can be active and pending at once: its handler runs while a fresh request from the same source waits, and that request is offered again once the handler completes.

A word-addressed register bus provides the following access:
- write-one set and clear pairs for the enable bits;
- write-one set and clear pairs for the pending bits;
- a read-only view of the active bits;
- the priority fields;
- a software trigger register.

An input `mask_all` holds back every request from the processor.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, all enable, pending, active and priority state is zero, `req_valid` is low and `run_prio` equals 2^PRIO_BITS (16 by default), the idle value.
- R2: Enable bits are set by writing ones at word 0x00+n/32 and cleared by writing ones at word 0x08+n/32. The bit position is n%32, and zero bits in the written data leave the state unchanged. A read of either word returns the current enable bits.
- R3: Pending bits follow the same layout, with set words at 0x10+n/32 and clear words at 0x18+n/32. A high level on `irq_in[n]` during a clock edge also sets pending bit n, and a set takes precedence over a clear in the same cycle.
- R4: The priority of line n is held at word 0x40+n/4, in bits [8*(n%4)+7 : 8*(n%4)+8-PRIO_BITS] of that word. All other bits of the byte read as zero.
- R5: A write to word 0x28 makes the line whose number is in bits [7:0] of the data pending. A number of NUM_LINES or above has no effect.
- R6: Among the lines that are pending and enabled, the block offers the one with the lowest priority number, and the lowest line number wins a tie. `req_valid`, `req_id` and `req_prio` are registered, so they reflect the state as it stood after the previous clock edge.
- R7: An `ack` moves the offered line from pending to active, and `req_valid` is low in the cycle after the `ack`.
- R8: If `irq_in[n]` is still high at the `ack` of line n, the line becomes active and stays pending. It is offered again after its `done`.
- R9: A request is offered only when its priority number is strictly below the running priority. A request of equal or lower urgency waits until the more urgent handlers complete.
- R10: `run_prio` is the lowest priority number among the active lines, or 2^PRIO_BITS when no line is active. It is registered.
- R11: A `done` strobe clears the active bit of line `done_id`. A `done` naming a line that is not active changes nothing.
- R12: While `mask_all` is high, `req_valid` is low in the following cycle.
- R13: Word 0x20+n/32 reads the active bits, one bit per line at position n%32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Level request lines |
| mask_all | input | 1 | Holds back all requests from the processor |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| req_valid | output | 1 | A request is offered to the processor |
| req_id | output | IDW | Line number of the offered request |
| req_prio | output | PRIO_BITS | Priority of the offered request |
| ack | input | 1 | Processor enters the handler for `req_id` |
| done | input | 1 | Processor leaves a handler |
| done_id | input | IDW | Line number of the handler being left |
| run_prio | output | PRIO_BITS+1 | Current running priority |

## Verification
The bench builds the block with NUM_LINES = 40 and PRIO_BITS = 4. With 40 lines the enable, pending and active groups span two words, with a partly filled upper word. Line numbers then reach a priority word whose byte lanes carry distinct values, so the n/32, n%32 and n/4 mapping is exercised beyond word 0. Four priority bits make the idle running priority 16. This lets nesting three handlers deep, and the equal-priority waiting case, be reached with small numbers.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam logic [7:0] A_EN_SET = 8'h00;
  localparam logic [7:0] A_EN_CLR = 8'h08;
  localparam logic [7:0] A_PD_SET = 8'h10;
  localparam logic [7:0] A_PD_CLR = 8'h18;
  localparam logic [7:0] A_ACT    = 8'h20;
  localparam logic [7:0] A_SWTRIG = 8'h28;
  localparam logic [7:0] A_PRIO   = 8'h40;
  localparam int unsigned MAX_LINES = 256;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N  = 40,
  parameter int unsigned PW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [N-1:0]          pend_i,
  input  logic [N-1:0]          act_i,
  output logic [N-1:0]          en_o,
  output logic [N-1:0][PW-1:0]  prio_o,
  output logic [N-1:0]          pend_set_o,
  output logic [N-1:0]          pend_clr_o
);
  logic [N-1:0]         en_q;
  logic [N-1:0][PW-1:0] prio_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam logic [7:0] WOFF = 8'(i / 32);
    localparam int unsigned BIT = i % 32;
    localparam logic [7:0] POFF = 8'(i / 4);
    localparam int unsigned LANE = i % 4;

    logic en_set, en_clr, pr_wr;
    assign en_set = bus_wr && (bus_addr == A_EN_SET + WOFF) && bus_wdata[BIT];
    assign en_clr = bus_wr && (bus_addr == A_EN_CLR + WOFF) && bus_wdata[BIT];
    assign pr_wr  = bus_wr && (bus_addr == A_PRIO + POFF);

    assign pend_set_o[i] = bus_wr &&
      (((bus_addr == A_PD_SET + WOFF) && bus_wdata[BIT]) ||
       ((bus_addr == A_SWTRIG) && (bus_wdata[7:0] == 8'(i))));
    assign pend_clr_o[i] = bus_wr && (bus_addr == A_PD_CLR + WOFF) && bus_wdata[BIT];

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]   <= 1'b0;
        prio_q[i] <= '0;
      end else begin
        if (en_set)      en_q[i] <= 1'b1;
        else if (en_clr) en_q[i] <= 1'b0;
        if (pr_wr) prio_q[i] <= bus_wdata[8*LANE+8-PW +: PW];
      end
    end
  end

  assign en_o   = en_q;
  assign prio_o = prio_q;

  logic [MAX_LINES-1:0]         en_pad, pd_pad, act_pad;
  logic [MAX_LINES-1:0][PW-1:0] prio_pad;
  always_comb begin
    en_pad   = '0;
    pd_pad   = '0;
    act_pad  = '0;
    prio_pad = '0;
    en_pad[N-1:0]   = en_q;
    pd_pad[N-1:0]   = pend_i;
    act_pad[N-1:0]  = act_i;
    prio_pad[N-1:0] = prio_q;
  end

  logic [31:0] rd_next;
  logic [7:0]  bit_base;
  assign bit_base = {bus_addr[2:0], 5'b0};

  always_comb begin
    rd_next = '0;
    if (bus_addr[7:3] == A_EN_SET[7:3] || bus_addr[7:3] == A_EN_CLR[7:3])
      rd_next = en_pad[bit_base +: 32];
    else if (bus_addr[7:3] == A_PD_SET[7:3] || bus_addr[7:3] == A_PD_CLR[7:3])
      rd_next = pd_pad[bit_base +: 32];
    else if (bus_addr[7:3] == A_ACT[7:3])
      rd_next = act_pad[bit_base +: 32];
    else if (bus_addr[7:6] == A_PRIO[7:6]) begin
      for (int ln = 0; ln < 4; ln++)
        rd_next[8*ln+8-PW +: PW] = prio_pad[{bus_addr[5:0], 2'(ln)}];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int unsigned N   = 40,
  parameter int unsigned IDW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   irq_in,
  input  logic [N-1:0]   pend_set,
  input  logic [N-1:0]   pend_clr,
  input  logic           ack,
  input  logic [IDW-1:0] ack_id,
  input  logic           done,
  input  logic [IDW-1:0] done_id,
  output logic [N-1:0]   pend_o,
  output logic [N-1:0]   act_o
);
  logic [N-1:0] pend_q, act_q;

  for (genvar i = 0; i < N; i++) begin : g_st
    logic ack_hit, done_hit;
    assign ack_hit  = ack  && (ack_id  == IDW'(i));
    assign done_hit = done && (done_id == IDW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        act_q[i]  <= 1'b0;
      end else begin
        if (irq_in[i] || pend_set[i])      pend_q[i] <= 1'b1;
        else if (pend_clr[i] || ack_hit)   pend_q[i] <= 1'b0;
        if (ack_hit)       act_q[i] <= 1'b1;
        else if (done_hit) act_q[i] <= 1'b0;
      end
    end

    // R7: entering a handler retires the pending request
    p_ack_retires_r7: assert property (@(posedge clk) disable iff (rst)
      ack_hit && !irq_in[i] && !pend_set[i] |=> !pend_q[i] && act_q[i]);
    // R8: a request still held at entry leaves the line active and pending
    p_level_holds_r8: assert property (@(posedge clk) disable iff (rst)
      ack_hit && irq_in[i] |=> pend_q[i] && act_q[i]);
    // R11: completing an inactive line leaves it inactive
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
      done_hit && !act_q[i] && !ack_hit |=> !act_q[i]);
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N   = 40,
  parameter int unsigned PW  = 4,
  parameter int unsigned IDW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         pend_i,
  input  logic [N-1:0]         en_i,
  input  logic [N-1:0]         act_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  input  logic                 mask_all,
  input  logic                 ack,
  output logic                 req_valid,
  output logic [IDW-1:0]       req_id,
  output logic [PW-1:0]        req_prio,
  output logic [PW:0]          run_prio
);
  localparam logic [PW:0] IDLE = {1'b1, {PW{1'b0}}};

  logic [PW:0]    best_p, run_p;
  logic [IDW-1:0] best_i;
  logic           fire;

  always_comb begin
    best_p = IDLE;
    best_i = '0;
    run_p  = IDLE;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && en_i[i] && ({1'b0, prio_i[i]} < best_p)) begin
        best_p = {1'b0, prio_i[i]};
        best_i = IDW'(i);
      end
      if (act_i[i] && ({1'b0, prio_i[i]} < run_p))
        run_p = {1'b0, prio_i[i]};
    end
    fire = !mask_all && (best_p < run_p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_id    <= '0;
      req_prio  <= '0;
      run_prio  <= IDLE;
    end else begin
      req_valid <= fire && !ack;
      req_id    <= best_i;
      req_prio  <= best_p[PW-1:0];
      run_prio  <= run_p;
    end
  end

  // R12: global mask holds back every request
  p_mask_blocks_r12: assert property (@(posedge clk) disable iff (rst)
    mask_all |=> !req_valid);
  // R7: an accepted request is withdrawn for a cycle
  p_ack_drops_r7: assert property (@(posedge clk) disable iff (rst)
    ack |=> !req_valid);
  // R10: no active line means idle running priority
  p_idle_run_r10: assert property (@(posedge clk) disable iff (rst)
    (act_i == '0) |=> (run_prio == IDLE));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NUM_LINES = 40,
  parameter int unsigned PRIO_BITS = 4,
  localparam int unsigned IDW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 mask_all,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 req_valid,
  output logic [IDW-1:0]       req_id,
  output logic [PRIO_BITS-1:0] req_prio,
  input  logic                 ack,
  input  logic                 done,
  input  logic [IDW-1:0]       done_id,
  output logic [PRIO_BITS:0]   run_prio
);
  logic [NUM_LINES-1:0]                en, pend, act, pset, pclr;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio;

  irq_regs #(.N(NUM_LINES), .PW(PRIO_BITS)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend),
    .act_i(act), .en_o(en), .prio_o(prio), .pend_set_o(pset),
    .pend_clr_o(pclr)
  );

  irq_state #(.N(NUM_LINES), .IDW(IDW)) u_state (
    .clk(clk), .rst(rst), .irq_in(irq_in), .pend_set(pset),
    .pend_clr(pclr), .ack(ack), .ack_id(req_id), .done(done),
    .done_id(done_id), .pend_o(pend), .act_o(act)
  );

  irq_arbiter #(.N(NUM_LINES), .PW(PRIO_BITS), .IDW(IDW)) u_arb (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .act_i(act),
    .prio_i(prio), .mask_all(mask_all), .ack(ack), .req_valid(req_valid),
    .req_id(req_id), .req_prio(req_prio), .run_prio(run_prio)
  );
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int unsigned NL = 40;
  localparam int unsigned PB = 4;
  localparam int unsigned IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq_in = '0;
  logic          mask_all = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          req_valid;
  logic [IW-1:0] req_id;
  logic [PB-1:0] req_prio;
  logic          ack = 1'b0;
  logic          done = 1'b0;
  logic [IW-1:0] done_id = '0;
  logic [PB:0]   run_prio;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NUM_LINES(NL), .PRIO_BITS(PB)) u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_all(mask_all),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .req_valid(req_valid), .req_id(req_id),
    .req_prio(req_prio), .ack(ack), .done(done), .done_id(done_id),
    .run_prio(run_prio)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_done(input int id);
    done = 1'b1; done_id = IW'(id); @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 run_prio", 32'(run_prio), 16);
    rd(8'h00, d); chk("R1 enable word", d, 0);
    rd(8'h48, d); chk("R1 priority word", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h01, 32'h8);                       // line 35
    rd(8'h01, d); chk("R2 set read", d, 32'h8);
    rd(8'h09, d); chk("R2 clear-word read", d, 32'h8);
    wr(8'h09, 32'h0);
    rd(8'h01, d); chk("R2 write zero ignored", d, 32'h8);
    wr(8'h09, 32'h8);
    rd(8'h01, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(8'h48, 32'hA53CF17E);                // lines 32..35
    rd(8'h48, d); chk("R4 lanes upper nibble", d, 32'hA030F070);
    wr(8'h48, 32'h0);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    wr(8'h10, 32'h20);
    rd(8'h10, d); chk("R3 bus set", d, 32'h20);
    wr(8'h18, 32'h20);
    rd(8'h18, d); chk("R3 bus clear", d, 0);
    irq_in[7] = 1'b1; @(negedge clk); irq_in[7] = 1'b0;
    rd(8'h10, d); chk("R3 level sets", d, 32'h80);
    wr(8'h18, 32'h80);
  endtask

  task automatic t_swtrig();
    logic [31:0] d;
    wr(8'h28, 32'd38);
    rd(8'h11, d); chk("R5 trigger line 38", d, 32'h40);
    wr(8'h19, 32'h40);
    wr(8'h28, 32'd200);
    rd(8'h10, d); chk("R5 out of range word0", d, 0);
    rd(8'h11, d); chk("R5 out of range word1", d, 0);
  endtask

  task automatic t_arb();
    wr(8'h40, 32'h00500000);                // line 2 -> 5
    wr(8'h42, 32'h00003000);                // line 9 -> 3
    wr(8'h48, 32'h00003000);                // line 33 -> 3
    wr(8'h00, 32'h204);                     // enable 2, 9
    wr(8'h01, 32'h2);                       // enable 33
    wr(8'h10, 32'h204);
    wr(8'h11, 32'h2);
    settle();
    chk("R6 valid", 32'(req_valid), 1);
    chk("R6 tie lowest line", 32'(req_id), 9);
    chk("R6 prio", 32'(req_prio), 3);
    wr(8'h18, 32'h200);
    settle();
    chk("R6 next winner", 32'(req_id), 33);
    wr(8'h19, 32'h2);
    settle();
    chk("R6 remaining", 32'(req_id), 2);
    wr(8'h18, 32'h4);
    settle();
    chk("R6 none pending", 32'(req_valid), 0);
  endtask

  task automatic t_mask();
    wr(8'h10, 32'h4);
    mask_all = 1'b1;
    settle();
    chk("R12 masked", 32'(req_valid), 0);
    mask_all = 1'b0;
    settle();
    chk("R12 unmasked", 32'(req_valid), 1);
    chk("R12 unmasked id", 32'(req_id), 2);
  endtask

  task automatic t_ack();                   // line 2 pending from t_mask
    logic [31:0] d;
    pulse_ack();
    chk("R7 valid drops", 32'(req_valid), 0);
    @(negedge clk);
    chk("R10 running prio", 32'(run_prio), 5);
    rd(8'h20, d); chk("R13 active word", d, 32'h4);
    rd(8'h10, d); chk("R7 pending cleared", d, 0);
    pulse_done(2);
    settle();
    chk("R10 idle again", 32'(run_prio), 16);
    rd(8'h20, d); chk("R11 active cleared", d, 0);
  endtask

  task automatic t_nest();
    wr(8'h10, 32'h4);
    settle(); pulse_ack(); settle();          // line 2 active, run 5
    wr(8'h11, 32'h2);                        // line 33, prio 3
    settle();
    chk("R9 preempt valid", 32'(req_valid), 1);
    chk("R9 preempt id", 32'(req_id), 33);
    pulse_ack(); settle();
    chk("R10 nested run", 32'(run_prio), 3);
    wr(8'h10, 32'h200);                      // line 9, prio 3
    settle();
    chk("R9 equal waits", 32'(req_valid), 0);
    pulse_done(33); settle();
    chk("R9 served after done", 32'(req_valid), 1);
    chk("R9 served id", 32'(req_id), 9);
    pulse_ack(); settle();
    pulse_done(9); pulse_done(2); settle();
    chk("R10 unwound", 32'(run_prio), 16);
  endtask

  task automatic t_reassert();
    logic [31:0] d;
    irq_in[2] = 1'b1;
    settle();
    pulse_ack(); settle();
    rd(8'h10, d); chk("R8 still pending", d, 32'h4);
    rd(8'h20, d); chk("R8 active", d, 32'h4);
    chk("R8 not re-offered", 32'(req_valid), 0);
    irq_in[2] = 1'b0;
    pulse_done(2); settle();
    chk("R8 offered again", 32'(req_valid), 1);
    chk("R8 id", 32'(req_id), 2);
    pulse_ack(); pulse_done(2); settle();
  endtask

  task automatic t_done_ignore();
    logic [31:0] d;
    wr(8'h10, 32'h200);
    settle(); pulse_ack(); settle();          // line 9 active
    pulse_done(2); settle();
    rd(8'h20, d); chk("R11 inactive done ignored", d, 32'h200);
    chk("R11 run kept", 32'(run_prio), 3);
    pulse_done(9); settle();
    rd(8'h20, d); chk("R11 done clears", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_prio();
    t_pend();
    t_swtrig();
    t_arb();
    t_mask();
    t_ack();
    t_nest();
    t_reassert();
    t_done_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule